// File: doc/BRIEF.md
# Compare Match Timer

A memory-mapped periodic timer with a parameterised number of channels. Each channel owns a prescaler, an up-counter, a compare register and a control/status register. One shared run register holds a single run bit per channel. A running channel counts on every prescaler tick. When the count equals the compare value on a tick, the counter returns to zero and the channel's match flag is set. The result is a periodic event whose period is (compare + 1) ticks. The match flag can drive a level interrupt.

The block is built in one of two variants, selected by `CNT_W`. The narrow variant (`CNT_W=16`) uses 16-bit registers at a 2-byte stride. The wide variant (`CNT_W=32`) uses a 4-byte stride, 32-bit counter and compare registers, and 16-bit control and run registers. The wide variant also has a second flag that records a counter overflow from all ones to zero. Software keeps the other channels' run bits intact by reading the run register, modifying it and writing it back.

Each channel has a two-state machine. `CH_HALTED` moves to `CH_COUNTING` on the transition RUN_SET, taken when the channel's run bit reads 1. `CH_COUNTING` returns to `CH_HALTED` on RUN_CLEAR, taken when the run bit reads 0. The prescaler and the counter advance only in `CH_COUNTING`.

Top module: `cmt_timer`

## Requirements
- R1: After reset all run bits are 0, every counter reads 0, every compare register reads all ones and every control/status register reads 0.
- R2: The run register is at byte address 0. Channel c sits at base (c+1)*4*S, where S is 2 (narrow) or 4 (wide). Control/status is at base, the counter at base+S and compare at base+2*S. Every other address reads 0 and ignores writes.
- R3: Run bit c (bit position c of the run register) enables channel c. The channel's state follows its run bit one clock later. A halted channel holds its count, and writing the run register changes only the bits written.
- R4: Control bits [2:0] select the divide. The narrow variant divides by 2^(3*min(sel,3)), so sel 3 gives 512. The wide variant divides by 1 for sel 0 and by 2^(sel-1) otherwise, so sel 4 gives 8. With divide 2^k, the first count lands on the (2^k+1)-th clock edge after the edge that writes the run bit.
- R5: On a tick with count equal to compare, the count becomes 0 and the match flag is set. The match flag is bit 7 (narrow) or bit 15 (wide).
- R6: A compare value below the current count gives no match until the counter wraps past all ones to 0. In the wide variant that wrap sets the overflow flag, bit 14.
- R7: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R8: `irq[c]` is the match flag AND control bit 6 of channel c. It is held as a level until the flag is cleared.
- R9: A software write to the counter overrides a tick in the same cycle. Compare may be rewritten while running and is used from the next tick.
- R10: Control bits [6:0] (narrow) or [13:0] (wide) are stored as written. Other non-flag bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from bus_addr |
| irq | output | NCH | Per-channel level interrupt |

## Verification
The bench targets the wrap when a compare value sits below the count. A design using a greater-or-equal compare would fire immediately instead of after the wrap, and a missing overflow flag would leave bit 14 clear. It measures the exact edge of the first count under the largest divide, which catches an off-by-one prescaler or a missing state lag. It also checks that writing 1 to a flag keeps it, and that a flag is set again while software clears it. Random writes race counter and compare updates against ticks, so a design that lets a tick beat a counter write diverges from the model on the next clock.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

    typedef enum logic {
        CH_HALTED,
        CH_COUNTING
    } ch_state_e;

    localparam int PRESC_W = 9;
    localparam int IE_BIT  = 6;
    localparam int OVF_BIT = 14;

    // log2 of the divide ratio for a clock-select code
    function automatic int unsigned presc_log2(input int unsigned cnt_w, input logic [2:0] sel);
        int unsigned s;
        s = 32'(sel);
        if (cnt_w == 16) begin
            return (s >= 3) ? 32'd9 : 32'd3 * s;
        end
        return (s == 0) ? 32'd0 : s - 32'd1;
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] mask;
    int unsigned        lg;

    always_comb begin
        lg   = presc_log2(CNT_W, sel);
        mask = PRESC_W'((32'd1 << lg) - 32'd1);
        tick = active && ((presc_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (active) begin
            presc_q <= presc_q + PRESC_W'(1);
        end else begin
            presc_q <= '0;
        end
    end

    // R4: with a divide above one, ticks are never on adjacent edges
    p_no_double_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mask != '0) |=> (!tick || !$stable(sel)));

endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_csr,
    input  logic             wr_cnt,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    output logic [15:0]      csr_rd,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             irq
);
    localparam int          FM_BIT    = (CNT_W == 16) ? 7 : 15;
    localparam logic [15:0] CTRL_MASK = (CNT_W == 16) ? 16'h007F : 16'h3FFF;

    ch_state_e   state_q, state_d;
    logic        active;
    logic        tick;
    logic [15:0] ctrl_q;
    logic        fm_q;
    logic        ovf_flag;
    logic        match_hit;
    logic        wrap_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALTED;
        else        state_q <= state_d;
    end

    // next state: RUN_SET and RUN_CLEAR
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALTED:   if (run)  state_d = CH_COUNTING;
            CH_COUNTING: if (!run) state_d = CH_HALTED;
        endcase
    end

    // state outputs
    always_comb begin
        active = (state_q == CH_COUNTING);
    end

    cmt_prescaler #(.CNT_W(CNT_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .sel    (ctrl_q[2:0]),
        .tick   (tick)
    );

    always_comb begin
        match_hit = tick && (cnt_q == cmp_q);
        wrap_hit  = tick && (cnt_q != cmp_q) && (&cnt_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (match_hit) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '1;
        else if (wr_cmp) cmp_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            fm_q   <= 1'b0;
        end else if (wr_csr) begin
            ctrl_q <= wdata[15:0] & CTRL_MASK;
            fm_q   <= match_hit | (fm_q & wdata[FM_BIT]);
        end else begin
            fm_q   <= fm_q | match_hit;
        end
    end

    generate
        if (CNT_W > 16) begin : g_ovf
            logic ovf_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      ovf_q <= 1'b0;
                else if (wr_csr) ovf_q <= wrap_hit | (ovf_q & wdata[OVF_BIT]);
                else             ovf_q <= ovf_q | wrap_hit;
            end
            assign ovf_flag = ovf_q;
        end else begin : g_no_ovf
            assign ovf_flag = 1'b0;
        end
    endgenerate

    always_comb begin
        csr_rd          = ctrl_q;
        csr_rd[FM_BIT]  = fm_q;
        csr_rd[OVF_BIT] = ovf_flag;
        irq             = fm_q & ctrl_q[IE_BIT];
    end

    // R5: a tick at the compare value returns to zero and raises the flag
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt_q == cmp_q) |=> (cnt_q == '0 && fm_q));

    // R7: hardware set beats a clearing write in the same cycle
    p_hw_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == cmp_q) |=> fm_q);

    // R8: the interrupt level is held until a control/status write
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_csr) |=> irq);

    // R3: a halted channel keeps its count
    p_halt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALTED && !wr_cnt) |=> $stable(cnt_q));

    // R6: away from compare and all ones, a tick only increments
    p_late_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && cnt_q != cmp_q && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/cmt_timer.sv
`timescale 1ns/1ps
module cmt_timer #(
    parameter int NCH   = 2,
    parameter int CNT_W = 16,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic [NCH-1:0]   irq
);
    localparam int STRIDE  = CNT_W / 8;
    localparam int CH_SPAN = 4 * STRIDE;

    logic [NCH-1:0]   run_q;
    logic [15:0]      csr_rd [NCH];
    logic [CNT_W-1:0] cnt_rd [NCH];
    logic [CNT_W-1:0] cmp_rd [NCH];
    logic             wr_run;

    always_comb wr_run = bus_wr && (bus_addr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (wr_run) run_q <= bus_wdata[NCH-1:0];
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam logic [AW-1:0] BASE = AW'((c + 1) * CH_SPAN);
            cmt_channel #(.CNT_W(CNT_W)) u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .run    (run_q[c]),
                .wr_csr (bus_wr && bus_addr == BASE),
                .wr_cnt (bus_wr && bus_addr == BASE + AW'(STRIDE)),
                .wr_cmp (bus_wr && bus_addr == BASE + AW'(2 * STRIDE)),
                .wdata  (bus_wdata),
                .csr_rd (csr_rd[c]),
                .cnt_q  (cnt_rd[c]),
                .cmp_q  (cmp_rd[c]),
                .irq    (irq[c])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata = CNT_W'(run_q);
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == AW'((c + 1) * CH_SPAN))              bus_rdata = CNT_W'(csr_rd[c]);
            if (bus_addr == AW'((c + 1) * CH_SPAN + STRIDE))     bus_rdata = cnt_rd[c];
            if (bus_addr == AW'((c + 1) * CH_SPAN + 2 * STRIDE)) bus_rdata = cmp_rd[c];
        end
    end

    // R3: the run register takes exactly the written bits
    p_start_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_run |=> run_q == $past(bus_wdata[NCH-1:0]));

endmodule

// File: tb/tb_cmt_timer.sv
`timescale 1ns/1ps
module tb_cmt_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [7:0]  b_addr [2];
    logic        b_wr   [2];
    logic [31:0] b_wd   [2];
    logic [15:0] rd0;
    logic [31:0] rd1;
    logic [1:0]  irq0, irq1;

    cmt_timer #(.NCH(2), .CNT_W(16), .AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr[0]), .bus_addr(b_addr[0]),
        .bus_wdata(b_wd[0][15:0]), .bus_rdata(rd0), .irq(irq0));
    cmt_timer #(.NCH(2), .CNT_W(32), .AW(8)) dut_w (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr[1]), .bus_addr(b_addr[1]),
        .bus_wdata(b_wd[1]), .bus_rdata(rd1), .irq(irq1));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state, [variant][channel]
    longint m_cnt [2][2];
    longint m_cmp [2][2];
    int     m_ctrl[2][2];
    bit     m_fm  [2][2];
    bit     m_fo  [2][2];
    bit     m_run [2][2];
    bit     m_st  [2][2];
    int     m_pres[2][2];

    function automatic longint vmax(int v);
        return (v == 1) ? 64'hFFFF_FFFF : 64'hFFFF;
    endfunction
    function automatic int fbit(int v);
        return (v == 1) ? 15 : 7;
    endfunction
    function automatic int strd(int v);
        return (v == 1) ? 4 : 2;
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [63:0] rdv(int v);
        return (v == 1) ? {32'd0, rd1} : {48'd0, rd0};
    endfunction
    function automatic logic [1:0] irqv(int v);
        return (v == 1) ? irq1 : irq0;
    endfunction

    function automatic logic [63:0] mread(int v, int a);
        int s = strd(v);
        longint r = 0;
        if (a == 0) r = longint'(m_run[v][0]) | (longint'(m_run[v][1]) << 1);
        for (int c = 0; c < 2; c++) begin
            int base = (c + 1) * 4 * s;
            if (a == base) r = longint'(m_ctrl[v][c]) | (longint'(m_fm[v][c]) << fbit(v))
                             | (longint'(m_fo[v][c]) << 14);
            if (a == base + s)     r = m_cnt[v][c];
            if (a == base + 2 * s) r = m_cmp[v][c];
        end
        return r;
    endfunction

    task automatic mreset();
        for (int v = 0; v < 2; v++)
            for (int c = 0; c < 2; c++) begin
                m_cnt[v][c] = 0; m_cmp[v][c] = vmax(v); m_ctrl[v][c] = 0;
                m_fm[v][c] = 0; m_fo[v][c] = 0; m_run[v][c] = 0;
                m_st[v][c] = 0; m_pres[v][c] = 0;
            end
    endtask

    task automatic mstep(int v);
        longint mx = vmax(v);
        int s = strd(v);
        int fb = fbit(v);
        int cmask = (v == 1) ? 32'h3FFF : 32'h007F;
        bit wr = b_wr[v];
        int a = int'(b_addr[v]);
        longint wd = longint'(b_wd[v]) & mx;
        for (int c = 0; c < 2; c++) begin
            int base = (c + 1) * 4 * s;
            int sel = m_ctrl[v][c] & 7;
            int lg = (v == 0) ? ((sel >= 3) ? 9 : 3 * sel) : ((sel == 0) ? 0 : sel - 1);
            int mk = (1 << lg) - 1;
            bit tk = m_st[v][c] && ((m_pres[v][c] & mk) == mk);
            bit mh = tk && (m_cnt[v][c] == m_cmp[v][c]);
            bit oh = (v == 1) && tk && !mh && (m_cnt[v][c] == mx);
            m_pres[v][c] = m_st[v][c] ? ((m_pres[v][c] + 1) % 512) : 0;
            m_st[v][c] = m_run[v][c];
            if (wr && a == base + s) m_cnt[v][c] = wd;
            else if (tk) m_cnt[v][c] = mh ? 0 : ((m_cnt[v][c] + 1) & mx);
            if (wr && a == base + 2 * s) m_cmp[v][c] = wd;
            if (wr && a == base) begin
                m_ctrl[v][c] = int'(wd) & cmask;
                m_fm[v][c] = mh | (m_fm[v][c] & wd[fb]);
                m_fo[v][c] = oh | (m_fo[v][c] & wd[14]);
            end else begin
                m_fm[v][c] = m_fm[v][c] | mh;
                m_fo[v][c] = m_fo[v][c] | oh;
            end
        end
        if (wr && a == 0) begin
            m_run[v][0] = wd[0];
            m_run[v][1] = wd[1];
        end
    endtask

    // reference model advanced and compared on every clock
    always @(posedge clk) begin
        if (!rst_n) mreset();
        else begin
            mstep(0);
            mstep(1);
        end
        #5;
        if (rst_n && !done) begin
            for (int v = 0; v < 2; v++) begin
                chk("R2 read path vs model", rdv(v), mread(v, int'(b_addr[v])));
                for (int c = 0; c < 2; c++)
                    chk("R8 irq vs model", 64'(irqv(v)[c]),
                        64'(m_fm[v][c] & ((m_ctrl[v][c] >> 6) & 1)));
            end
        end
    end

    task automatic wr(int v, int a, longint d);
        @(negedge clk);
        b_wr[v] = 1'b1; b_addr[v] = 8'(a); b_wd[v] = 32'(d);
        @(negedge clk);
        b_wr[v] = 1'b0;
    endtask

    task automatic rd(int v, int a, output logic [63:0] val);
        @(negedge clk);
        b_addr[v] = 8'(a); b_wr[v] = 1'b0;
        @(posedge clk);
        #6;
        val = rdv(v);
    endtask

    task automatic run_variant(int v);
        int s = strd(v);
        int fb = fbit(v);
        int c0 = 4 * s;
        int c1 = 8 * s;
        longint mx = vmax(v);
        logic [63:0] val, va, vb;
        int n;
        int k = (v == 1) ? 3 : 9;

        // R1 reset values
        rd(v, 0, val);            chk("R1 run reg", val, 0);
        rd(v, c0, val);           chk("R1 csr", val, 0);
        rd(v, c0 + s, val);       chk("R1 counter", val, 0);
        rd(v, c0 + 2 * s, val);   chk("R1 compare", 64'(val), 64'(mx));

        // R10 control storage, R7 writing 1 to a clear flag keeps it clear
        wr(v, c0, 16'hFFFF);
        rd(v, c0, val);           chk("R10 R7 csr mask", val, (v == 1) ? 64'h3FFF : 64'h007F);

        // R5 periodic match with div 1 and interrupt enabled
        wr(v, c0, 16'h0040);
        wr(v, c0 + 2 * s, 3);
        wr(v, c0 + s, 0);
        rd(v, 0, val);
        wr(v, 0, val | 1);
        repeat (12) @(negedge clk);
        rd(v, c0, val);           chk("R5 match flag", (val >> fb) & 1, 1);
        chk("R8 irq raised", 64'(irqv(v)[0]), 1);

        // R3 stop keeps other bits and freezes the count
        rd(v, 0, val);
        wr(v, 0, val & ~64'd1);
        repeat (3) @(negedge clk);
        rd(v, c0 + s, va);
        repeat (5) @(negedge clk);
        rd(v, c0 + s, vb);        chk("R3 halted count held", vb, va);

        // R7 flag write semantics, R8 irq drop
        wr(v, c0, 16'h0040 | (1 << fb));
        rd(v, c0, val);           chk("R7 write one keeps flag", (val >> fb) & 1, 1);
        wr(v, c0, 16'h0040);
        rd(v, c0, val);           chk("R7 write zero clears flag", (val >> fb) & 1, 0);
        chk("R8 irq dropped", 64'(irqv(v)[0]), 0);

        // R4 largest divide used by the standard configuration
        wr(v, c0, (v == 1) ? 4 : 3);
        wr(v, c0 + s, 0);
        wr(v, c0 + 2 * s, mx);
        wr(v, 0, 1);
        n = 0;
        do begin
            rd(v, c0 + s, val);
            n++;
        end while (val == 0 && n < 2000);
        chk("R4 first count edge", 64'(n), 64'(1 << k));

        // R3 second channel started with read-modify-write
        rd(v, 0, val);
        wr(v, 0, val | 2);
        rd(v, 0, val);            chk("R3 both run bits", val, 3);

        // R6 compare below count: wrap first, then match
        wr(v, 0, 0);
        wr(v, c0, 16'h0040);
        wr(v, c0 + 2 * s, 2);
        wr(v, c0 + s, mx - 2);
        wr(v, 0, 1);
        rd(v, c0 + s, val);
        rd(v, c0 + s, val);
        rd(v, c0, val);           chk("R6 wrap without match", val, 64'h40 | ((v == 1) ? 64'h4000 : 0));
        rd(v, c0 + s, val);       chk("R6 count after wrap", val, 1);
        rd(v, c0 + s, val);
        rd(v, c0, val);           chk("R6 match after wrap", (val >> fb) & 1, 1);

        // R9 counter write while running
        wr(v, c0 + 2 * s, 1000);
        wr(v, c0 + s, 500);
        rd(v, c0 + s, val);       chk("R9 counter overwrite", val, 502);

        // R2 unmapped addresses and the second channel's compare
        rd(v, 12 * s, val);       chk("R2 unmapped read", val, 0);
        rd(v, 1, val);            chk("R2 odd address read", val, 0);
        rd(v, c1 + 2 * s, val);   chk("R2 channel 1 compare", 64'(val), 64'(mx));

        // random races checked by the per-cycle model (R7, R9)
        for (int i = 0; i < 300; i++) begin
            int c = int'($urandom_range(0, 1));
            int base = (c + 1) * 4 * s;
            int pick = int'($urandom_range(0, 4));
            @(negedge clk);
            b_wr[v] = ($urandom_range(0, 2) != 0);
            case (pick)
                0: begin b_addr[v] = 8'(base); b_wd[v] = $urandom & 32'hC041; end
                1: begin b_addr[v] = 8'(base + s); b_wd[v] = $urandom_range(0, 7); end
                2: begin b_addr[v] = 8'(base + 2 * s); b_wd[v] = $urandom_range(0, 7); end
                3: begin b_addr[v] = 8'(0); b_wd[v] = $urandom_range(0, 3); end
                default: begin b_addr[v] = 8'(base + s); b_wd[v] = 32'(mx - 1); end
            endcase
        end
        @(negedge clk);
        b_wr[v] = 1'b0;
    endtask

    initial begin
        for (int v = 0; v < 2; v++) begin
            b_addr[v] = '0; b_wr[v] = 1'b0; b_wd[v] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_variant(0);
        run_variant(1);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule